// File: doc/BRIEF.md
# MAC Coprocessor Pipeline Hazard Checker

This block follows multiply-accumulate coprocessor instructions through a four-stage pipeline: fetch, then decode, then execute, then writeback. It flags instructions that break the coprocessor's scheduling rule. A decoder upstream presents one instruction descriptor per cycle. The descriptor holds five bits: valid, uses-MAC, reads-MAC-register, coprocessor-store and parallel-move. Each descriptor moves forward one stage per clock, and the pipeline never stalls.

The scheduling rule concerns instructions that read a MAC register. Two such reads must be separated by at least one instruction that does not use the MAC. The coprocessor-store instruction is exempt from this spacing. When an instruction breaks the rule, the checker raises a hazard pulse in the cycle that instruction sits in decode. The block also drives stage strobes for the following events:
- the double-word fetch of a MAC instruction;
- the accumulator and flag update at the end of execute;
- the operand write-back in writeback, which happens only for parallel moves.

The strobes let a surrounding model or a monitor time these events.

Top module: `mac_hazard_pipe`

## Requirements
- R1: A synchronous active-high reset clears all four stage valids and all strobe outputs. It also discards any record of an earlier MAC-register read, so the first read after reset never raises a hazard.
- R2: A descriptor presented at a rising edge occupies fetch after that edge. It is in decode after the next edge, in execute after the one after that, and in writeback after the one after that. `stage_vld_o` bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 writeback.
- R3: `fetch_dw_o` is high exactly when the fetch stage holds a valid descriptor with uses-MAC set. This marks a double-word MAC fetch.
- R4: A descriptor is a MAC read when it is valid and has both uses-MAC and reads-MAC set. `hazard_o` is high for one cycle while a MAC read that is not a coprocessor store sits in decode, if the previous MAC read left decode with no non-MAC instruction after it.
- R5: A MAC read with the coprocessor-store bit set never raises a hazard. It still counts as a MAC read for the next instruction.
- R6: A bubble (an invalid descriptor) or a valid descriptor with uses-MAC clear is a non-MAC instruction, and it separates reads. A valid MAC instruction that does not read neither separates nor counts as a read.
- R7: `acc_upd_o` is high exactly when execute holds a valid descriptor with uses-MAC set and the coprocessor-store bit clear.
- R8: `opnd_wb_o` is high exactly when writeback holds a valid descriptor with both uses-MAC and parallel-move set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor valid |
| in_uses_mac | input | 1 | Instruction uses the MAC |
| in_reads_mac | input | 1 | Instruction reads a MAC register |
| in_is_store | input | 1 | Instruction is the coprocessor store |
| in_par_move | input | 1 | Instruction has a parallel data move |
| stage_vld_o | output | 4 | Stage valids (bit 0 fetch to bit 3 writeback) |
| fetch_dw_o | output | 1 | Double-word MAC fetch in fetch stage |
| hazard_o | output | 1 | Spacing violation by the instruction in decode |
| acc_upd_o | output | 1 | Accumulator and flag update in execute |
| opnd_wb_o | output | 1 | Operand write-back in writeback |

## Verification
The hardest case to reach from the ports is the spacing record across a long run of MAC instructions that do not read. Such a run must carry a pending read forward unchanged until a later read arrives, and a later store must also leave a pending read behind it. Every ordered pair of the 32 descriptor codes is fed back to back, which covers every neighbour combination. A long pseudo-random stream then produces runs of non-reading MAC instructions between reads. Reset is asserted with a read pending and the pipeline full, and a read follows it at once.

// File: rtl/mac_hazard_pipe.sv
module mac_hazard_pipe (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_uses_mac,
  input  logic       in_reads_mac,
  input  logic       in_is_store,
  input  logic       in_par_move,
  output logic [3:0] stage_vld_o,
  output logic       fetch_dw_o,
  output logic       hazard_o,
  output logic       acc_upd_o,
  output logic       opnd_wb_o
);
  localparam int NST = 4;
  localparam int VB = 0, UB = 1, RB = 2, SB = 3, PB = 4;

  logic [4:0] st [NST];
  logic       rd_pending;

  wire [4:0] din = {in_par_move, in_is_store, in_reads_mac, in_uses_mac, in_valid};
  wire d_mac   = st[1][VB] & st[1][UB];
  wire d_read  = d_mac & st[1][RB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NST; i++) st[i] <= '0;
      rd_pending <= 1'b0;
    end else begin
      st[0] <= din;
      for (int i = 1; i < NST; i++) st[i] <= st[i-1];
      if (!d_mac)      rd_pending <= 1'b0;
      else if (d_read) rd_pending <= 1'b1;
    end
  end

  for (genvar g = 0; g < NST; g++) begin : g_vld
    assign stage_vld_o[g] = st[g][VB];
  end

  assign fetch_dw_o = st[0][VB] & st[0][UB];
  assign hazard_o   = d_read & ~st[1][SB] & rd_pending;
  assign acc_upd_o  = st[2][VB] & st[2][UB] & ~st[2][SB];
  assign opnd_wb_o  = st[3][VB] & st[3][UB] & st[3][PB];
endmodule

module mac_hazard_pipe_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_uses_mac,
  input logic       in_reads_mac,
  input logic       in_is_store,
  input logic [3:0] stage_vld_o,
  input logic       fetch_dw_o,
  input logic       hazard_o,
  input logic       acc_upd_o,
  input logic       opnd_wb_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (stage_vld_o == 4'b0 && !hazard_o));
  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stage_vld_o[3:1] == $past(stage_vld_o[2:0]));
  // R3
  fetch_dw_chk: assert property (@(posedge clk) disable iff (rst) fetch_dw_o |-> stage_vld_o[0]);
  // R4
  hazard_src_chk: assert property (@(posedge clk) disable iff (rst)
    hazard_o |-> $past(in_valid && in_uses_mac && in_reads_mac, 2));
  // R5
  store_exempt_chk: assert property (@(posedge clk) disable iff (rst)
    hazard_o |-> !$past(in_is_store, 2));
  // R7
  acc_upd_chk: assert property (@(posedge clk) disable iff (rst) acc_upd_o |-> stage_vld_o[2]);
  // R8
  opnd_wb_chk: assert property (@(posedge clk) disable iff (rst) opnd_wb_o |-> stage_vld_o[3]);
endmodule

bind mac_hazard_pipe mac_hazard_pipe_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_uses_mac(in_uses_mac),
  .in_reads_mac(in_reads_mac), .in_is_store(in_is_store),
  .stage_vld_o(stage_vld_o), .fetch_dw_o(fetch_dw_o), .hazard_o(hazard_o),
  .acc_upd_o(acc_upd_o), .opnd_wb_o(opnd_wb_o)
);

// File: tb/mac_hazard_pipe_test.sv
module mac_hazard_pipe_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_uses_mac = 0, in_reads_mac = 0, in_is_store = 0, in_par_move = 0;
  logic [3:0] stage_vld_o;
  logic fetch_dw_o, hazard_o, acc_upd_o, opnd_wb_o;

  int checks = 0, fails = 0;
  logic [4:0] m [4];
  logic m_pend;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_hazard_pipe uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uses_mac(in_uses_mac),
    .in_reads_mac(in_reads_mac), .in_is_store(in_is_store), .in_par_move(in_par_move),
    .stage_vld_o(stage_vld_o), .fetch_dw_o(fetch_dw_o), .hazard_o(hazard_o),
    .acc_upd_o(acc_upd_o), .opnd_wb_o(opnd_wb_o));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // descriptor bits: 0 valid, 1 uses, 2 reads, 3 store, 4 par
  task automatic check_all();
    logic [3:0] ev;
    logic rd;
    for (int i = 0; i < 4; i++) ev[i] = m[i][0];
    chk("R2", stage_vld_o, ev);
    chk("R3", {3'b0, fetch_dw_o}, {3'b0, m[0][0] & m[0][1]});
    rd = m[1][0] & m[1][1] & m[1][2];
    chk(m[1][3] ? "R5" : "R4/R6", {3'b0, hazard_o}, {3'b0, rd & ~m[1][3] & m_pend});
    chk("R7", {3'b0, acc_upd_o}, {3'b0, m[2][0] & m[2][1] & ~m[2][3]});
    chk("R8", {3'b0, opnd_wb_o}, {3'b0, m[3][0] & m[3][1] & m[3][4]});
  endtask

  task automatic cycle(input logic [4:0] d, input logic r);
    {in_par_move, in_is_store, in_reads_mac, in_uses_mac, in_valid} = d;
    rst = r;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 4; i++) m[i] = '0;
      m_pend = 0;
    end else begin
      if (!(m[1][0] & m[1][1])) m_pend = 0;
      else if (m[1][2]) m_pend = 1;
      for (int i = 3; i > 0; i--) m[i] = m[i-1];
      m[0] = d;
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 4; i++) m[i] = '0;
    m_pend = 0;
    @(negedge clk);
    cycle(5'b0, 1'b1);
    // R1: reset state
    chk("R1", stage_vld_o, 4'b0);
    chk("R1", {hazard_o, fetch_dw_o, acc_upd_o, opnd_wb_o}, 4'b0);
    // all ordered pairs of descriptor codes
    for (int p = 0; p < 1024; p++) begin
      cycle(5'(p), 1'b0);
      cycle(5'(p >> 5), 1'b0);
    end
    // pseudo-random stream
    lfsr = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle({lfsr[4], lfsr[3] & lfsr[7], lfsr[2], lfsr[1], lfsr[0] | lfsr[9]}, 1'b0);
    end
    // R1: reset with read pending and full pipe, then read immediately
    for (int k = 0; k < 4; k++) cycle(5'b10111, 1'b0);
    cycle(5'b00111, 1'b1);
    chk("R1", stage_vld_o, 4'b0);
    cycle(5'b00111, 1'b0);
    cycle(5'b00111, 1'b0);
    chk("R1", {3'b0, hazard_o}, 4'b0);
    cycle(5'b00000, 1'b0);
    chk("R4", {3'b0, hazard_o}, 4'b1);
    for (int k = 0; k < 6; k++) cycle(5'b0, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule